// File: doc/BRIEF.md
# Dual SATA Bridge Bring-Up Sequencer

This block brings either of two parallel-ATA-to-SATA adapter bridges online with no software polling. A start request enables the selected bridge's peripheral clock and lets it settle. The block then loads the bridge control word, waits again, and samples the bridge's PHY-ready status at a fixed interval. It stops at the first ready sample or when the time budget runs out. If the budget runs out, the block reports an error and gates that bridge's clock again.

A reset request works like a start request, with two differences. It opens with a one-cycle reset pulse to the bridge instead of a clock enable, and it never touches the clock. A stop request gates a clock at once.

All waits are counted in millisecond ticks. A clock divider produces the ticks, and it restarts at the beginning of every phase, so each wait lasts exactly its number of milliseconds times `TICK_DIV` cycles. The routing mode comes from a 3-bit input, and only values 0 to 3 are legal. The mode decides whether the bridge's slave-enable bit is set.

Top module: `sata_bridge_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle. After it, `busy`, `done`, `err`, both `clk_en` bits, both `online` bits and both control words are 0. This holds even when the reset arrives in the middle of an operation.
- R2: A legal start request sets `clk_en[sel]` and `busy` on its accepting edge. The control word stays unchanged for `PRE_MS*TICK_DIV` cycles and is loaded on the edge after that.
- R3: A loaded control word always has bit 4 (hotplug detect enable) and bit 0 (bridge enable) set. All bits other than 4, 1 and 0 are clear.
- R4: Bit 1 (slave enable) is set for bridge 0 only when the mode is 2, and for bridge 1 only when the mode is 3.
- R5: After the load, the block waits `SETTLE_MS` ms and then samples `phy_rdy[sel]` once every `POLL_MS` ms. On the first sample that reads 1, it pulses `done` with `err` low. Counted in edges after the accepting edge, that pulse comes at `(PRE_MS+SETTLE_MS)*TICK_DIV + 1 + k*POLL_MS*TICK_DIV` for the k-th sample.
- R6: Sampling stops after the k-th sample once `SETTLE_MS + k*POLL_MS >= TIMEOUT_MS`. The result is the value read at that last sample: if it reads 0, `done` and `err` pulse together.
- R7: When a start operation fails, `clk_en` of that bridge is cleared on the same edge as `done`; when it succeeds, the clock stays on. `online[sel]` is cleared when an operation on that bridge is accepted and is set on success.
- R8: A legal reset request drives `rst_pulse[sel]` high for exactly one cycle after the accepting edge. It then follows the R2 and R5/R6 timing and leaves `clk_en` unchanged, even when it fails.
- R9: A stop request in idle clears `clk_en[sel]` on its edge. Any request with `sel` equal to 2 or 3 changes nothing.
- R10: A start or reset request with mode 4 to 7 pulses `done` and `err` on its accepting edge. It does not set `busy` and changes neither `clk_en` nor the control words.
- R11: While `busy` is high, all requests are ignored.
- R12: When strobes coincide in idle, start wins over reset, and reset wins over stop.
- R13: `done` is a one-cycle pulse, `err` is high only together with `done`, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Start strobe for the selected bridge |
| reset_req | input | 1 | Reset-and-setup strobe for the selected bridge |
| stop_req | input | 1 | Clock-gate strobe for the selected bridge |
| sel | input | 2 | Bridge selector; only 0 and 1 act |
| mode | input | 3 | Routing mode; 0 to 3 legal |
| phy_rdy | input | 2 | PHY-ready status, one bit per bridge |
| clk_en | output | 2 | Peripheral clock enable per bridge |
| rst_pulse | output | 2 | One-cycle bridge reset per bridge |
| ctrl0 | output | 16 | Control word of bridge 0 |
| ctrl1 | output | 16 | Control word of bridge 1 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| online | output | 2 | Last operation on that bridge succeeded |

## Verification
The tightest collision is between the last PHY-ready sample and the timeout: on that final sample the block must still record a success. The bench places the ready rise one cycle before that sample in one vector and exactly at it in the next. It expects `done` on the same edge in both cases, with `err` low in the first and high in the second. It also fires start, reset and stop together, expecting only the clock enable and no reset pulse.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int CTRL_W = 16;
  localparam int BIT_EN = 0;
  localparam int BIT_SLV = 1;
  localparam int BIT_HP = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_WRITE,
    S_SETTLE,
    S_POLL
  } seq_state_t;

  function automatic logic [1:0] bridge_mask(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  function automatic logic mode_legal(input logic [2:0] m);
    return m[2] == 1'b0;
  endfunction

  // slave enable follows the bridge and the routing mode
  function automatic logic [CTRL_W-1:0] ctrl_word(input logic b, input logic [2:0] m);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[BIT_EN] = 1'b1;
    w[BIT_HP] = 1'b1;
    w[BIT_SLV] = b ? (m == 3'd3) : (m == 3'd2);
    return w;
  endfunction

  // number of samples until settle + k*poll reaches the budget
  function automatic int max_polls(input int budget, input int settle, input int poll);
    int n;
    n = (budget - settle + poll - 1) / poll;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sbs_tick.sv
module sbs_tick #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sbs_bridge_regs.sv
module sbs_bridge_regs
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_on,
  input  logic              clk_off,
  input  logic              rst_fire,
  input  logic              ctrl_load,
  input  logic [CTRL_W-1:0] ctrl_val,
  input  logic              online_clr,
  input  logic              online_set,
  output logic              clk_en,
  output logic              rst_pulse,
  output logic [CTRL_W-1:0] ctrl,
  output logic              online
);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en    <= 1'b0;
      rst_pulse <= 1'b0;
      ctrl      <= '0;
      online    <= 1'b0;
    end else begin
      if (clk_on) clk_en <= 1'b1;
      else if (clk_off) clk_en <= 1'b0;
      rst_pulse <= rst_fire;
      if (ctrl_load) ctrl <= ctrl_val;
      if (online_clr) online <= 1'b0;
      else if (online_set) online <= 1'b1;
    end
  end

  a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  a_r3_ctrl_fields: assert property (@(posedge clk) disable iff (rst)
    (ctrl != '0) |-> (ctrl[BIT_EN] && ctrl[BIT_HP]));

endmodule

// File: rtl/sbs_seq.sv
module sbs_seq
  import sbs_pkg::*;
#(
  parameter int PRE_MS     = 10,
  parameter int SETTLE_MS  = 10,
  parameter int POLL_MS    = 100,
  parameter int TIMEOUT_MS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_req,
  input  logic              reset_req,
  input  logic              stop_req,
  input  logic [1:0]        sel,
  input  logic [2:0]        mode,
  input  logic [1:0]        phy_rdy,
  output logic              restart,
  output logic [1:0]        clk_on,
  output logic [1:0]        clk_off,
  output logic [1:0]        rst_fire,
  output logic [1:0]        ctrl_load,
  output logic [CTRL_W-1:0] ctrl_val,
  output logic [1:0]        online_clr,
  output logic [1:0]        online_set,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cur_b,
  output logic              start_active,
  output logic              timeout_fail
);
  localparam int MAXP = max_polls(TIMEOUT_MS, SETTLE_MS, POLL_MS);
  localparam int MSW  = $clog2(max3(PRE_MS, SETTLE_MS, POLL_MS) + 1);
  localparam int PW   = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam logic [MSW-1:0] PRE_L    = MSW'(PRE_MS - 1);
  localparam logic [MSW-1:0] SETTLE_L = MSW'(SETTLE_MS - 1);
  localparam logic [MSW-1:0] POLL_L   = MSW'(POLL_MS - 1);
  localparam logic [PW-1:0]  LASTP    = PW'(MAXP - 1);

  seq_state_t     state;
  logic           op_start;
  logic [2:0]     cur_mode;
  logic [MSW-1:0] ms_cnt;
  logic [PW-1:0]  poll_cnt;
  logic [MSW-1:0] lim;

  logic idle, sel_ok, nb, pick_start, pick_reset, pick_stop;
  logic accept, go, bad, timed, phase_end, sample, pass;

  always_comb begin
    case (state)
      S_PRE:    lim = PRE_L;
      S_SETTLE: lim = SETTLE_L;
      default:  lim = POLL_L;
    endcase
  end

  assign idle       = (state == S_IDLE);
  assign sel_ok     = !sel[1];
  assign nb         = sel[0];
  assign pick_start = start_req;
  assign pick_reset = reset_req && !start_req;
  assign pick_stop  = stop_req && !start_req && !reset_req;
  assign accept     = idle && sel_ok && (pick_start || pick_reset);
  assign go         = accept && mode_legal(mode);
  assign bad        = accept && !mode_legal(mode);
  assign timed      = (state == S_PRE) || (state == S_SETTLE) || (state == S_POLL);
  assign phase_end  = timed && tick && (ms_cnt == lim);
  assign sample     = (state == S_POLL) && phase_end;
  assign pass       = sample && phy_rdy[cur_b];
  assign timeout_fail = sample && !phy_rdy[cur_b] && (poll_cnt == LASTP);
  assign restart    = go || (state == S_WRITE) || phase_end;

  assign clk_on     = (go && pick_start) ? bridge_mask(nb) : 2'b00;
  assign rst_fire   = (go && pick_reset) ? bridge_mask(nb) : 2'b00;
  assign clk_off    = ((idle && sel_ok && pick_stop) ? bridge_mask(nb) : 2'b00)
                    | ((timeout_fail && op_start) ? bridge_mask(cur_b) : 2'b00);
  assign ctrl_load  = (state == S_WRITE) ? bridge_mask(cur_b) : 2'b00;
  assign ctrl_val   = ctrl_word(cur_b, cur_mode);
  assign online_clr = accept ? bridge_mask(nb) : 2'b00;
  assign online_set = pass ? bridge_mask(cur_b) : 2'b00;
  assign busy         = !idle;
  assign start_active = busy && op_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur_b    <= 1'b0;
      op_start <= 1'b0;
      cur_mode <= '0;
      ms_cnt   <= '0;
      poll_cnt <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= pass || timeout_fail || bad;
      err  <= timeout_fail || bad;
      if (restart) ms_cnt <= '0;
      else if (tick) ms_cnt <= ms_cnt + 1'b1;
      case (state)
        S_IDLE: if (go) begin
          state    <= S_PRE;
          cur_b    <= nb;
          op_start <= pick_start;
          cur_mode <= mode;
          poll_cnt <= '0;
        end
        S_PRE:    if (phase_end) state <= S_WRITE;
        S_WRITE:  state <= S_SETTLE;
        S_SETTLE: if (phase_end) state <= S_POLL;
        S_POLL: if (sample) begin
          poll_cnt <= poll_cnt + 1'b1;
          if (pass || timeout_fail) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r13_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r13_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r6_poll_bounded: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL) |-> (poll_cnt <= LASTP));

endmodule

// File: rtl/sata_bridge_seq.sv
module sata_bridge_seq
  import sbs_pkg::*;
#(
  parameter int TICK_DIV   = 100000,
  parameter int PRE_MS     = 10,
  parameter int SETTLE_MS  = 10,
  parameter int POLL_MS    = 100,
  parameter int TIMEOUT_MS = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_req,
  input  logic        reset_req,
  input  logic        stop_req,
  input  logic [1:0]  sel,
  input  logic [2:0]  mode,
  input  logic [1:0]  phy_rdy,
  output logic [1:0]  clk_en,
  output logic [1:0]  rst_pulse,
  output logic [15:0] ctrl0,
  output logic [15:0] ctrl1,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [1:0]  online
);
  logic              tick, restart;
  logic [1:0]        clk_on, clk_off, rst_fire, ctrl_load, online_clr, online_set;
  logic [CTRL_W-1:0] ctrl_val;
  logic [CTRL_W-1:0] ctrl_arr [2];
  logic              cur_b, start_active, timeout_fail;

  sbs_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  sbs_seq #(
    .PRE_MS(PRE_MS), .SETTLE_MS(SETTLE_MS),
    .POLL_MS(POLL_MS), .TIMEOUT_MS(TIMEOUT_MS)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .start_req(start_req), .reset_req(reset_req), .stop_req(stop_req),
    .sel(sel), .mode(mode), .phy_rdy(phy_rdy),
    .restart(restart), .clk_on(clk_on), .clk_off(clk_off),
    .rst_fire(rst_fire), .ctrl_load(ctrl_load), .ctrl_val(ctrl_val),
    .online_clr(online_clr), .online_set(online_set),
    .busy(busy), .done(done), .err(err),
    .cur_b(cur_b), .start_active(start_active), .timeout_fail(timeout_fail)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_bridge
    sbs_bridge_regs u_regs (
      .clk(clk), .rst(rst),
      .clk_on(clk_on[gi]), .clk_off(clk_off[gi]), .rst_fire(rst_fire[gi]),
      .ctrl_load(ctrl_load[gi]), .ctrl_val(ctrl_val),
      .online_clr(online_clr[gi]), .online_set(online_set[gi]),
      .clk_en(clk_en[gi]), .rst_pulse(rst_pulse[gi]),
      .ctrl(ctrl_arr[gi]), .online(online[gi])
    );
  end

  assign ctrl0 = ctrl_arr[0];
  assign ctrl1 = ctrl_arr[1];

  a_r2_clock_held: assert property (@(posedge clk) disable iff (rst)
    start_active |-> clk_en[cur_b]);

  a_r7_fail_gates: assert property (@(posedge clk) disable iff (rst)
    (timeout_fail && start_active) |=> !clk_en[$past(cur_b)]);

  a_r8_single_reset: assert property (@(posedge clk) disable iff (rst)
    $countones(rst_pulse) <= 1);

endmodule

// File: tb/sata_bridge_seq_test.sv
`timescale 1ns/1ps
module sata_bridge_seq_test;
  localparam int D = 4, A = 2, S = 2, P = 5, T = 30;
  localparam int NV = 10;
  // {op(1: reset), sel, mode[2:0], rdy_at[7:0], exp_err, exp_slave}
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'd0,   1'b0, 1'b0},
    {1'b0, 1'b1, 3'd3, 8'd60,  1'b0, 1'b1},
    {1'b0, 1'b0, 3'd2, 8'd0,   1'b0, 1'b1},
    {1'b0, 1'b1, 3'd2, 8'd255, 1'b1, 1'b0},
    {1'b1, 1'b0, 3'd1, 8'd0,   1'b0, 1'b0},
    {1'b1, 1'b1, 3'd3, 8'd255, 1'b1, 1'b1},
    {1'b0, 1'b0, 3'd5, 8'd0,   1'b1, 1'b0},
    {1'b0, 1'b1, 3'd3, 8'd136, 1'b0, 1'b1},
    {1'b0, 1'b1, 3'd0, 8'd137, 1'b1, 1'b0},
    {1'b1, 1'b1, 3'd7, 8'd0,   1'b1, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic start_i = 0, reset_i = 0, stop_i = 0;
  logic [1:0] sel_i = 0, phy_i = 0;
  logic [2:0] mode_i = 0;
  logic [1:0] clk_en, rst_pulse, online;
  logic [15:0] ctrl0, ctrl1;
  logic busy, done, err;
  int n_cmp = 0, n_bad = 0;
  logic [1:0] clk_model = 2'b00;

  always #2 clk = ~clk;

  sata_bridge_seq #(.TICK_DIV(D), .PRE_MS(A), .SETTLE_MS(S), .POLL_MS(P),
                    .TIMEOUT_MS(T)) uut (
    .clk(clk), .rst(rst), .start_req(start_i), .reset_req(reset_i),
    .stop_req(stop_i), .sel(sel_i), .mode(mode_i), .phy_rdy(phy_i),
    .clk_en(clk_en), .rst_pulse(rst_pulse), .ctrl0(ctrl0), .ctrl1(ctrl1),
    .busy(busy), .done(done), .err(err), .online(online));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // edge count of the done pulse: first ready sample, or the last sample
  function automatic int exp_edges(input int rdy);
    int base, t;
    base = A * D + 1 + S * D;
    t = base + P * D;
    for (int k = 1; k < 100; k++) begin
      t = base + k * P * D;
      if (t - 1 >= rdy) return t;
      if (S + k * P >= T) return t;
    end
    return t;
  endfunction

  task automatic run_vec(input logic op, input logic bsel, input logic [2:0] m,
                         input int rdy, input logic x_err, input logic x_slv);
    logic legal;
    logic [15:0] prev, x_ctrl;
    int n, x_n;
    string tg;
    legal = (m < 3'd4);
    prev = bsel ? ctrl1 : ctrl0;
    x_ctrl = legal ? (16'h0011 | {14'd0, x_slv, 1'b0}) : prev;
    if (legal && !op) clk_model[bsel] = !x_err;
    x_n = legal ? exp_edges(rdy) : 0;
    tg = !legal ? "R10" : (x_err ? "R6" : "R5");
    @(negedge clk);
    sel_i = {1'b0, bsel}; mode_i = m; start_i = !op; reset_i = op;
    phy_i = 2'b00; phy_i[bsel] = (rdy == 0);
    @(posedge clk); @(negedge clk);
    start_i = 0; reset_i = 0;
    if (legal) begin
      chk("R2 busy", busy, 1);
      if (!op) chk("R2 clk_en on", clk_en[bsel], 1);
      else chk("R8 rst_pulse", rst_pulse, bsel ? 2 : 1);
    end else chk("R10 busy", busy, 0);
    n = 0;
    while (!done && n < 1000) begin
      phy_i[bsel] = (n >= rdy);
      @(posedge clk); @(negedge clk);
      n++;
      if (legal && op && n == 1) chk("R8 pulse width", rst_pulse, 0);
      if (legal && n == A * D) chk("R2 ctrl not yet", bsel ? ctrl1 : ctrl0, prev);
      if (legal && n == A * D + 1) chk("R3 ctrl load", bsel ? ctrl1 : ctrl0, x_ctrl);
    end
    chk({tg, " done edge"}, n, x_n);
    chk({tg, " err"}, err, x_err);
    chk("R7 clk_en", clk_en, clk_model);
    chk("R7 online", online[bsel], !x_err);
    @(negedge clk);
    chk("R13 done pulse", done, 0);
    chk("R4 ctrl word", bsel ? ctrl1 : ctrl0, x_ctrl);
    phy_i = 2'b00;
  endtask

  task automatic strobe(input logic s, input logic r, input logic p,
                        input logic [1:0] bs, input logic [2:0] m);
    @(negedge clk);
    start_i = s; reset_i = r; stop_i = p; sel_i = bs; mode_i = m;
    @(posedge clk); @(negedge clk);
    start_i = 0; reset_i = 0; stop_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 state after reset
    chk("R1 clk_en", clk_en, 0); chk("R1 ctrl0", ctrl0, 0); chk("R1 ctrl1", ctrl1, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 online", online, 0);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][14], VEC[i][13], VEC[i][12:10], int'(VEC[i][9:2]),
              VEC[i][1], VEC[i][0]);

    // R9: selector 2 and 3 ignored, then a real stop
    strobe(0, 0, 1, 2'd2, 3'd0);
    chk("R9 sel2 ignored", clk_en, 2'b01);
    strobe(1, 1, 0, 2'd3, 3'd0);
    chk("R9 sel3 ignored", busy, 0);
    strobe(0, 0, 1, 2'd0, 3'd0);
    chk("R9 stop gates", clk_en, 2'b00);

    // R12: all three strobes at once, start must win
    phy_i = 2'b10;
    strobe(1, 1, 1, 2'd1, 3'd0);
    chk("R12 clk_en", clk_en, 2'b10);
    chk("R12 no rst_pulse", rst_pulse, 0);
    chk("R12 busy", busy, 1);
    for (int c = 0; c < 1000 && !done; c++) @(negedge clk);
    chk("R12 err", err, 0);
    phy_i = 2'b00;

    // R11: requests during an operation are dropped; R1 reset mid-operation
    strobe(1, 0, 0, 2'd0, 3'd0);
    repeat (5) @(negedge clk);
    strobe(1, 0, 1, 2'd1, 3'd2);
    chk("R11 clk_en kept", clk_en, 2'b11);
    chk("R11 still busy", busy, 1);
    chk("R11 ctrl1 kept", ctrl1, 16'h0011);
    @(negedge clk); rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    chk("R1 busy mid-op", busy, 0);
    chk("R1 clk_en mid-op", clk_en, 0);
    chk("R1 ctrl mid-op", {ctrl0, ctrl1}, 0);
    chk("R1 online mid-op", online, 0);
    @(negedge clk);
    chk("R1 stays idle", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule